// File: doc/BRIEF.md
# Interleaved PFC Phase-Shedding Controller

This block decides, once per switching cycle, whether the second boost phase of a two-phase interleaved power-factor-correction stage keeps switching. It also sets the on-time that phase A uses. The voltage loop is observed only through digitized comparator flags:
- error-amplifier output under the shed level;
- error-amplifier output over the shed level plus hysteresis;
- error-amplifier output under the burst level.

A line half-cycle tick paces the shedding filter. A soft-start flag and a burst flag override the normal decision.

Phase B is dropped only after the low-load condition has held for a fixed number of line half-cycles. It is brought back as soon as the load rises past the hysteresis band. When phase B is off, the phase A on-time is doubled so that power delivery does not step, and the doubled value is clamped to the dual-phase maximum. Mode changes and on-time updates happen only on a switching-cycle boundary strobe, so a gate pulse is never cut short.

The block also keeps a latched high-line range select. A peak-detect flag sets it. It clears only after a low-line indication has held for a programmable number of half-cycles.

Top module: `pfc_phase_shed`

## Requirements
- R1: After synchronous reset, `phb_en` is 1 (dual-phase), `ton_a` is 0, `hi_range` is 0 and the half-cycle count is zero.
- R2: `phb_en` and `ton_a` change only at a clock edge where `cyc_strobe` is 1. Between strobes they hold their values whatever the other inputs do.
- R3: Phase B is dropped at a strobe only if the shed flag has been high on every clock for at least SHED_HC (default 14) `half_tick` pulses. Any clock with the shed flag low clears the count. The count saturates at SHED_HC and never wraps.
- R4: At a strobe where `cmp_over_hys` is 1, and soft start and burst are both inactive, `phb_en` becomes 1 at once, with no filter.
- R5: At a strobe where none of soft start, burst, `cmp_over_hys` and the completed filter applies, the mode is left unchanged (hysteresis band).
- R6: At a strobe, `ton_a` loads `min(ton_cmd, ton_max)` in dual-phase mode and `min(2*ton_cmd, ton_max)` in single-phase mode, using the mode chosen at that strobe.
- R7: At a strobe with `soft_start` high, `phb_en` becomes 1. This has priority over every other condition.
- R8: At a strobe with `cmp_under_burst` high and soft start inactive, `phb_en` becomes 0 immediately, bypassing the half-cycle filter. Burst has priority over `cmp_over_hys`.
- R9: A clock with `hi_line_pk` high sets `hi_range` to 1 on the next edge. The flag then stays set without needing `hi_line_pk`.
- R10: `hi_range` clears only after LO_HOLD (default 6) consecutive `half_tick` pulses with `lo_line_ind` high and `hi_line_pk` low. A clock with `lo_line_ind` low restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | Switching-cycle boundary; mode and on-time update here |
| half_tick | input | 1 | One-cycle pulse per line half-cycle |
| cmp_under_shed | input | 1 | Error-amp output below shed level |
| cmp_over_hys | input | 1 | Error-amp output above shed level plus hysteresis |
| cmp_under_burst | input | 1 | Error-amp output below burst level |
| soft_start | input | 1 | Soft start in progress |
| hi_line_pk | input | 1 | Line peak above high-line level |
| lo_line_ind | input | 1 | Low-line indication |
| ton_cmd | input | TW | Per-phase on-time command for dual-phase mode |
| ton_max | input | TW | Maximum dual-phase on-time |
| phb_en | output | 1 | Phase B switching enable |
| ton_a | output | TW | Phase A on-time |
| hi_range | output | 1 | Latched high-line range select |

## Verification
The shed flag is held through exactly SHED_HC-1 ticks, exactly SHED_HC ticks and more than SHED_HC ticks. This separates an early shed, the strobe on which the last tick lands (still dual), and a counter that wraps. A run that drops the shed flag for one clock partway through and then resumes shows whether the count restarts. The stimulus also includes these patterns:
- Strobes inside the hysteresis band in both modes, each followed by a strobe with the over-hysteresis flag set.
- Burst together with soft start, which shows the override order.
- A doubled command both below and above the limit, which shows the clamp.
- Low-line runs that are broken one tick short and then completed, which show the release condition of the range latch.

// File: rtl/pfc_shed_pkg.sv
package pfc_shed_pkg;
  typedef enum logic {
    PH_SINGLE = 1'b0,
    PH_DUAL   = 1'b1
  } phase_mode_e;
endpackage

// File: rtl/shed_filter.sv
module shed_filter #(
  parameter int SHED_HC = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic under_shed,
  output logic shed_ready
);
  localparam int CW = $clog2(SHED_HC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SHED_HC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!under_shed) begin
      cnt_q <= '0;
    end else if (half_tick && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shed_ready = (cnt_q == LIMIT);

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R3
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !under_shed |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/range_latch.sv
module range_latch #(
  parameter int LO_HOLD = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic hi_pk,
  input  logic lo_ind,
  output logic hi_range
);
  localparam int HW = (LO_HOLD > 1) ? $clog2(LO_HOLD) : 1;
  localparam logic [HW-1:0] LAST = HW'(LO_HOLD - 1);

  logic [HW-1:0] lcnt_q;
  logic          hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= 1'b0;
      lcnt_q <= '0;
    end else if (hi_pk) begin
      hi_q   <= 1'b1;
      lcnt_q <= '0;
    end else if (!lo_ind) begin
      lcnt_q <= '0;
    end else if (half_tick) begin
      if (lcnt_q == LAST) begin
        hi_q   <= 1'b0;
        lcnt_q <= '0;
      end else begin
        lcnt_q <= lcnt_q + 1'b1;
      end
    end
  end

  assign hi_range = hi_q;

  AST_HI_SETS: assert property (@(posedge clk) disable iff (rst)
    hi_pk |=> hi_range); // R9
  AST_HI_CLEAR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_range) |-> ($past(lo_ind) && $past(half_tick) && !$past(hi_pk))); // R10
endmodule

// File: rtl/ontime_scaler.sv
module ontime_scaler #(
  parameter int TW = 12
) (
  input  logic          dual,
  input  logic [TW-1:0] ton_cmd,
  input  logic [TW-1:0] ton_max,
  output logic [TW-1:0] ton_out
);
  logic [TW:0] want;

  always_comb begin
    want = dual ? {1'b0, ton_cmd} : {ton_cmd, 1'b0};
    if (want > {1'b0, ton_max}) ton_out = ton_max;
    else                        ton_out = want[TW-1:0];
  end
endmodule

// File: rtl/pfc_phase_shed.sv
module pfc_phase_shed
  import pfc_shed_pkg::*;
#(
  parameter int TW      = 12,
  parameter int SHED_HC = 14,
  parameter int LO_HOLD = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_strobe,
  input  logic          half_tick,
  input  logic          cmp_under_shed,
  input  logic          cmp_over_hys,
  input  logic          cmp_under_burst,
  input  logic          soft_start,
  input  logic          hi_line_pk,
  input  logic          lo_line_ind,
  input  logic [TW-1:0] ton_cmd,
  input  logic [TW-1:0] ton_max,
  output logic          phb_en,
  output logic [TW-1:0] ton_a,
  output logic          hi_range
);
  phase_mode_e   mode_q, mode_nx;
  logic          shed_ready;
  logic [TW-1:0] ton_nx, ton_q;

  shed_filter #(.SHED_HC(SHED_HC)) u_filter (
    .clk        (clk),
    .rst        (rst),
    .half_tick  (half_tick),
    .under_shed (cmp_under_shed),
    .shed_ready (shed_ready)
  );

  range_latch #(.LO_HOLD(LO_HOLD)) u_range (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick),
    .hi_pk     (hi_line_pk),
    .lo_ind    (lo_line_ind),
    .hi_range  (hi_range)
  );

  // Priority: soft start, burst, re-add, filtered shed, hold.
  always_comb begin
    if (soft_start)           mode_nx = PH_DUAL;
    else if (cmp_under_burst) mode_nx = PH_SINGLE;
    else if (cmp_over_hys)    mode_nx = PH_DUAL;
    else if (shed_ready)      mode_nx = PH_SINGLE;
    else                      mode_nx = mode_q;
  end

  ontime_scaler #(.TW(TW)) u_scale (
    .dual    (mode_nx == PH_DUAL),
    .ton_cmd (ton_cmd),
    .ton_max (ton_max),
    .ton_out (ton_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PH_DUAL;
      ton_q  <= '0;
    end else if (cyc_strobe) begin
      mode_q <= mode_nx;
      ton_q  <= ton_nx;
    end
  end

  assign phb_en = (mode_q == PH_DUAL);
  assign ton_a  = ton_q;

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (rst)
    !cyc_strobe |=> ($stable(phb_en) && $stable(ton_a))); // R2
  AST_SHED_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $fell(phb_en) |-> ($past(shed_ready) || $past(cmp_under_burst))); // R3
  AST_READD_NOW: assert property (@(posedge clk) disable iff (rst)
    (cyc_strobe && !soft_start && !cmp_under_burst && cmp_over_hys) |=> phb_en); // R4
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_strobe && !soft_start && !cmp_under_burst && !cmp_over_hys && !shed_ready)
      |=> $stable(phb_en)); // R5
  AST_TON_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    cyc_strobe |=> (ton_a <= $past(ton_max))); // R6
  AST_SOFT_DUAL: assert property (@(posedge clk) disable iff (rst)
    (cyc_strobe && soft_start) |=> phb_en); // R7
  AST_BURST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cyc_strobe && !soft_start && cmp_under_burst) |=> !phb_en); // R8
endmodule

// File: tb/tb_pfc_phase_shed.sv
module tb_pfc_phase_shed;
  localparam int TW = 12;
  localparam int HC = 14;
  localparam int LO = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb = 0, tick = 0, below = 0, above = 0, burst = 0, ss = 0, hipk = 0, lo = 0;
  logic [TW-1:0] cmd = '0, tmax = '0;
  logic phb_en, hi_range;
  logic [TW-1:0] ton_a;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  pfc_phase_shed #(.TW(TW), .SHED_HC(HC), .LO_HOLD(LO)) dut (
    .clk(clk), .rst(rst), .cyc_strobe(strb), .half_tick(tick),
    .cmp_under_shed(below), .cmp_over_hys(above), .cmp_under_burst(burst),
    .soft_start(ss), .hi_line_pk(hipk), .lo_line_ind(lo),
    .ton_cmd(cmd), .ton_max(tmax),
    .phb_en(phb_en), .ton_a(ton_a), .hi_range(hi_range)
  );

  typedef struct {
    logic          en;
    logic [TW-1:0] ton;
    logic          hi;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // reference state built from the requirements
  int  m_cnt = 0, m_lcnt = 0, m_ton = 0;
  bit  m_dual = 1, m_hi = 0;

  function automatic int clampv(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic step(input bit s, input bit t, input string tag);
    exp_t e;
    bit ready;
    @(negedge clk);
    strb = s; tick = t;
    ready = (m_cnt == HC);
    if (!below) m_cnt = 0;
    else if (t && m_cnt < HC) m_cnt++;
    if (s) begin
      if (ss)         m_dual = 1;
      else if (burst) m_dual = 0;
      else if (above) m_dual = 1;
      else if (ready) m_dual = 0;
      m_ton = m_dual ? clampv(int'(cmd), int'(tmax)) : clampv(2 * int'(cmd), int'(tmax));
    end
    if (hipk) begin m_hi = 1; m_lcnt = 0; end
    else if (!lo) m_lcnt = 0;
    else if (t) begin
      if (m_lcnt == LO - 1) begin m_hi = 0; m_lcnt = 0; end
      else m_lcnt++;
    end
    e.en = m_dual; e.ton = TW'(m_ton); e.hi = m_hi; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    strb = 0; tick = 0;
  endtask

  // monitor: compare after each edge
  always begin
    @(posedge clk); #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (phb_en !== e.en || ton_a !== e.ton || hi_range !== e.hi) begin
        n_fail++;
        $display("FAIL %s: got en=%0b ton=%0d hi=%0b, expected en=%0b ton=%0d hi=%0b",
                 e.tag, phb_en, ton_a, hi_range, e.en, e.ton, e.hi);
      end
    end
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    n_checks++;
    if (phb_en !== 1'b1 || ton_a !== '0 || hi_range !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got en=%0b ton=%0d hi=%0b, expected en=1 ton=0 hi=0",
               phb_en, ton_a, hi_range);
    end

    cmd = 100; tmax = 300;
    step(1, 0, "R6 dual on-time");
    cmd = 150;
    step(0, 0, "R2 no strobe holds on-time");

    below = 1;
    repeat (HC - 1) step(1, 1, "R3 filter not yet complete");
    step(1, 1, "R3 last tick lands, still dual");
    step(1, 0, "R3 shed after full filter, R6 doubled");
    repeat (3) step(1, 1, "R3 saturated count stays single");

    below = 0;
    step(1, 0, "R5 band holds single");
    above = 1;
    step(1, 0, "R4 immediate re-add, R6 halved");
    above = 0;

    below = 1;
    repeat (10) step(1, 1, "R3 partial count");
    below = 0;
    step(1, 0, "R3 flag drop");
    below = 1;
    repeat (5) step(1, 1, "R3 count restarted");
    below = 0;

    burst = 1; cmd = 200;
    step(1, 0, "R8 burst forces single, R6 clamp");
    ss = 1;
    step(1, 0, "R7 soft start beats burst");
    ss = 0; burst = 0;
    step(1, 0, "R5 band holds dual");
    burst = 1;
    step(0, 0, "R2 burst without strobe ignored");
    burst = 0;

    hipk = 1;
    step(0, 0, "R9 high line sets range");
    hipk = 0; lo = 1;
    repeat (LO - 1) step(0, 1, "R10 range held");
    lo = 0;
    step(0, 1, "R10 low-line break");
    lo = 1;
    repeat (LO - 1) step(0, 1, "R10 range held after restart");
    step(0, 1, "R10 range cleared");
    lo = 0;
    step(0, 0, "R10 stays clear");

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule